// File: doc/BRIEF.md
# Keyed Delayed Warm Reset Controller

This block is a single 8-bit register on a byte-wide local register bus. Any byte written to it is stored and can be read back. One key byte, 0x77, also arms a warm reset. The reset does not start at once. A delay timer runs for about 1.5 ms. It then drives one active-low pulse to every local reset domain at the same time. The host-side reset output is not part of that group. It follows only the power-on reset.

The pulse also clears the register's own stored value. The timer and the pulse logic are reset only by power-on. So a pulse, once it starts, always runs to its end. A second key write while a reset is pending does not restart the timer and does not extend the wait.

Top module: `warm_reset_ctrl`

## Requirements
- R1: After power-on reset is released, all local reset outputs are high (deasserted). The host reset output goes high within two clock edges. A read of the register returns 0x00.
- R2: A write with `addr_i` equal to 0x17 stores `wdata_i`. A read at 0x17 returns the stored byte on `rdata_o` one clock after the read strobe is sampled.
- R3: Writes at any other offset leave the register unchanged. Reads at any other offset, and cycles with no read, give 0x00 on `rdata_o`.
- R4: A write of exactly 0x77 at offset 0x17 arms a warm reset. Any other value at 0x17, or 0x77 written at another offset, arms nothing.
- R5: The local reset outputs go low no earlier than 1 ms and no later than 2 ms after the arming write. With the default 50 MHz clock, this is 50,000 to 100,000 cycles.
- R6: All local reset outputs are active low and go low together for exactly PULSE_CYC cycles (default 50 cycles, 1 µs). Bit 0 is the processor, bit 1 the system controller, bit 2 this register block, bit 3 local peripherals, and bit 4 the local PCI segment.
- R7: The host reset output `host_rst_no` is never driven low by a warm reset.
- R8: A key write while a reset is pending neither restarts nor extends the delay. The pulse still starts within the R5 window, measured from the first key write.
- R9: The warm reset pulse clears the stored register value to 0x00. A read after the pulse returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, asynchronous, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 8 | Byte offset in the register space |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, one cycle after the read strobe |
| local_rst_no | output | 5 | Active-low resets for the local domains |
| host_rst_no | output | 1 | Host-side reset, released after power-on only |

## Verification
The bench writes 0x77 at offsets other than 0x17, and values next to the key at 0x17. A decode that ignores the address, or compares only some of the data bits, would start a reset that should not happen. A second key write lands partway through the delay. If that write restarted the timer, the pulse would fall outside the 2 ms window measured from the first write. The bench measures the pulse width and checks that all domain bits move together. It also watches the host output for the whole run. Finally, it reads the register after the pulse: a design that kept the stored byte would return 0x77 instead of 0x00.

// File: rtl/wrst_pkg.sv
package wrst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_PULSE = 2'd2
  } wrst_state_e;

  localparam int unsigned DEF_CLK_HZ    = 50_000_000;
  localparam int unsigned DEF_NUM_LOCAL = 5;
  localparam logic [7:0]  DEF_KEY       = 8'h77;
  localparam logic [7:0]  DEF_REG_OFS   = 8'h17;
endpackage

// File: rtl/wrst_regif.sv
module wrst_regif #(
  parameter int unsigned    AW      = 8,
  parameter int unsigned    DW      = 8,
  parameter logic [AW-1:0]  REG_OFS = '0,
  parameter logic [DW-1:0]  KEY     = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          clr_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] reg_o,
  output logic          key_wr_o
);
  logic          hit;
  logic [DW-1:0] reg_q;
  logic [DW-1:0] rdata_q;

  assign hit = (addr_i == REG_OFS);

  // The warm reset clear takes priority over a write in the same cycle.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              reg_q <= '0;
    else if (clr_i)           reg_q <= '0;
    else if (wr_en_i && hit)  reg_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rdata_q <= '0;
    else if (rd_en_i && hit)  rdata_q <= reg_q;
    else                      rdata_q <= '0;
  end

  assign key_wr_o = wr_en_i && hit && (wdata_i == KEY) && !clr_i;
  assign rdata_o  = rdata_q;
  assign reg_o    = reg_q;
endmodule

// File: rtl/wrst_timer.sv
module wrst_timer
  import wrst_pkg::*;
#(
  parameter int unsigned DELAY_CYC = 75_000,
  parameter int unsigned PULSE_CYC = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  output logic busy_o,
  output logic pulse_o
);
  localparam int unsigned MAX_CYC = (DELAY_CYC > PULSE_CYC) ? DELAY_CYC : PULSE_CYC;
  localparam int unsigned CW      = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] DELAY_LAST = CW'(DELAY_CYC - 1);
  localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_CYC - 1);

  wrst_state_e   state_q;
  logic [CW-1:0] cnt_q;

  // Runs on power-on reset only, so a started pulse always completes.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (arm_i) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (cnt_q == DELAY_LAST) begin
            state_q <= ST_PULSE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_PULSE: begin
          if (cnt_q == PULSE_LAST) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          state_q <= ST_IDLE;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign pulse_o = (state_q == ST_PULSE);
endmodule

// File: rtl/wrst_fanout.sv
module wrst_fanout #(
  parameter int unsigned NUM_LOCAL = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pulse_i,
  output logic [NUM_LOCAL-1:0] local_rst_no,
  output logic                 host_rst_no
);
  for (genvar d = 0; d < NUM_LOCAL; d++) begin : g_dom
    logic rst_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rst_q <= 1'b0;
      else         rst_q <= !pulse_i;
    end
    assign local_rst_no[d] = rst_q;
  end

  // Host domain: released after power-on, untouched by the pulse.
  logic [1:0] host_sync_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) host_sync_q <= 2'b00;
    else         host_sync_q <= {host_sync_q[0], 1'b1};
  end
  assign host_rst_no = host_sync_q[1];
endmodule

// File: rtl/warm_reset_ctrl.sv
module warm_reset_ctrl
  import wrst_pkg::*;
#(
  parameter int unsigned   CLK_HZ    = DEF_CLK_HZ,
  parameter int unsigned   AW        = 8,
  parameter int unsigned   DW        = 8,
  parameter logic [AW-1:0] REG_OFS   = AW'(DEF_REG_OFS),
  parameter logic [DW-1:0] KEY       = DW'(DEF_KEY),
  parameter int unsigned   NUM_LOCAL = DEF_NUM_LOCAL,
  parameter int unsigned   DELAY_CYC = (CLK_HZ / 2000) * 3,
  parameter int unsigned   PULSE_CYC = (CLK_HZ >= 1_000_000) ? CLK_HZ / 1_000_000 : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic                 rd_en_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o,
  output logic [NUM_LOCAL-1:0] local_rst_no,
  output logic                 host_rst_no
);
  localparam int unsigned MIN_CYC = CLK_HZ / 1000;
  localparam int unsigned MAX_CYC = CLK_HZ / 500;

  logic          key_wr;
  logic          busy;
  logic          pulse;
  logic [DW-1:0] reg_val;

  wrst_regif #(
    .AW(AW), .DW(DW), .REG_OFS(REG_OFS), .KEY(KEY)
  ) u_regif (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .clr_i   (pulse),
    .rdata_o (rdata_o),
    .reg_o   (reg_val),
    .key_wr_o(key_wr)
  );

  wrst_timer #(
    .DELAY_CYC(DELAY_CYC), .PULSE_CYC(PULSE_CYC)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (key_wr),
    .busy_o (busy),
    .pulse_o(pulse)
  );

  wrst_fanout #(
    .NUM_LOCAL(NUM_LOCAL)
  ) u_fanout (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pulse_i     (pulse),
    .local_rst_no(local_rst_no),
    .host_rst_no (host_rst_no)
  );
endmodule

// File: rtl/wrst_checker.sv
module wrst_checker #(
  parameter int unsigned   AW        = 8,
  parameter int unsigned   DW        = 8,
  parameter logic [AW-1:0] REG_OFS   = '0,
  parameter logic [DW-1:0] KEY       = '0,
  parameter int unsigned   NUM_LOCAL = 5,
  parameter int unsigned   MIN_CYC   = 50_000,
  parameter int unsigned   MAX_CYC   = 100_000,
  parameter int unsigned   PULSE_CYC = 50
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 wr_en_i,
  input logic                 rd_en_i,
  input logic [AW-1:0]        addr_i,
  input logic [DW-1:0]        wdata_i,
  input logic [DW-1:0]        rdata_o,
  input logic [NUM_LOCAL-1:0] local_rst_no,
  input logic                 host_rst_no,
  input logic                 key_wr_i,
  input logic                 busy_i,
  input logic                 pulse_i,
  input logic [DW-1:0]        reg_i
);
  logic        hit;
  logic        key_seen;
  int unsigned dcnt_q;
  int unsigned pcnt_q;

  assign hit      = (addr_i == REG_OFS);
  assign key_seen = wr_en_i && hit && (wdata_i == KEY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  dcnt_q <= 0;
    else if (key_wr_i && !busy_i) dcnt_q <= 0;
    else if (busy_i && !pulse_i)  dcnt_q <= dcnt_q + 1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pcnt_q <= 0;
    else if (pulse_i) pcnt_q <= pcnt_q + 1;
    else              pcnt_q <= 0;
  end

  a_r2_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && hit) |=> (rdata_o == $past(reg_i)));

  a_r3_other_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_i && hit) |=> (rdata_o == '0));

  a_r4_key_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_seen && !busy_i) |=> (busy_i && (&local_rst_no)));

  a_r4_other_no_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !key_seen) |=> !busy_i);

  a_r5_delay_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_i) |-> (dcnt_q >= MIN_CYC && dcnt_q <= MAX_CYC));

  a_r6_width_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_i |-> (pcnt_q < PULSE_CYC));

  a_r6_width_exact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pulse_i) |-> (pcnt_q == PULSE_CYC));

  a_r6_all_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_i |=> (local_rst_no == '0));

  a_r6_all_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse_i |=> (&local_rst_no));

  a_r7_host_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(host_rst_no));

  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_i |=> (reg_i == '0));
endmodule

bind warm_reset_ctrl wrst_checker #(
  .AW(AW), .DW(DW), .REG_OFS(REG_OFS), .KEY(KEY), .NUM_LOCAL(NUM_LOCAL),
  .MIN_CYC(MIN_CYC), .MAX_CYC(MAX_CYC), .PULSE_CYC(PULSE_CYC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .rd_en_i     (rd_en_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .local_rst_no(local_rst_no),
  .host_rst_no (host_rst_no),
  .key_wr_i    (key_wr),
  .busy_i      (busy),
  .pulse_i     (pulse),
  .reg_i       (reg_val)
);

// File: tb/tb_warm_reset_ctrl.sv
module tb_warm_reset_ctrl;
  localparam logic [7:0] OFS    = 8'h17;
  localparam logic [7:0] KEYV   = 8'h77;
  localparam int         LO_CYC = 50_000;
  localparam int         HI_CYC = 100_000;
  localparam int         PW     = 50;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [4:0] lrst_n;
  logic       hrst_n;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;

  bit  mon_en = 1'b0;
  bit  key_mark = 1'b0;
  bit  key_taken = 1'b0;
  int  since_key = 0;
  int  fall_at = -1;
  int  falls = 0;
  int  low_len = 0;
  int  mixed = 0;
  int  host_bad = 0;
  logic [4:0] prev_l = '1;
  logic [7:0] exp_reg = '0;

  always #10 clk = ~clk;

  warm_reset_ctrl dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .wr_en_i     (wr_en),
    .rd_en_i     (rd_en),
    .addr_i      (addr),
    .wdata_i     (wdata),
    .rdata_o     (rdata),
    .local_rst_no(lrst_n),
    .host_rst_no (hrst_n)
  );

  function automatic logic [7:0] exp_read(input logic [7:0] a, input logic [7:0] r);
    return (a == OFS) ? r : 8'h00;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    if (a == OFS && d == KEYV && !key_taken) begin
      key_mark = 1'b1;
      key_taken = 1'b1;
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  // Sample the outputs on the falling edge, away from the active clock edge.
  always @(negedge clk) begin
    if (mon_en) begin
      if (key_mark) begin
        since_key = 0;
        key_mark  = 1'b0;
      end else begin
        since_key++;
      end
      if (lrst_n != 5'h1f && lrst_n != 5'h00) mixed++;
      if (prev_l == 5'h1f && lrst_n == 5'h00) begin
        falls++;
        if (fall_at < 0) fall_at = since_key;
      end
      if (lrst_n == 5'h00) low_len++;
      if (!hrst_n) host_bad++;
      prev_l = lrst_n;
    end
  end

  initial begin
    repeat (200_000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 local", lrst_n, 5'h1f);
    chk("R1 host", hrst_n, 1'b1);
    bus_rd(OFS, rd);
    chk("R1 reg", rd, 8'h00);
    mon_en = 1'b1;

    // R2/R3/R4: random bus traffic, the key never lands at the register offset
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      logic [7:0] d;
      a = ($urandom % 3 == 0) ? OFS : 8'($urandom);
      d = ($urandom % 4 == 0) ? KEYV : 8'($urandom);
      if (a == OFS && d == KEYV) d = 8'h76;
      if ($urandom % 2 == 0) begin
        bus_wr(a, d);
        if (a == OFS) exp_reg = d;
      end else begin
        bus_rd(a, rd);
        chk((a == OFS) ? "R2 readback" : "R3 other read", rd, exp_read(a, exp_reg));
      end
    end

    // R4: values next to the key, and the key at neighbouring offsets
    bus_wr(OFS, 8'h76);
    bus_wr(OFS, 8'hF7);
    bus_wr(8'h16, KEYV);
    bus_wr(8'h18, KEYV);
    bus_wr(8'h97, KEYV);
    bus_rd(OFS, rd);
    chk("R3 reg kept", rd, 8'hF7);
    repeat (3000) @(posedge clk);
    chk("R4 no arm", falls, 0);
    chk("R4 outputs idle", lrst_n, 5'h1f);

    // R5/R8: first key write, a second one partway through the delay
    bus_wr(OFS, KEYV);
    repeat (20_000) @(posedge clk);
    bus_rd(OFS, rd);
    chk("R2 key latched", rd, KEYV);
    chk("R5 not early", falls, 0);
    repeat (10_000) @(posedge clk);
    bus_wr(OFS, KEYV);
    while (falls == 0) @(negedge clk);
    repeat (PW + 20) @(negedge clk);

    chk("R5 window", (fall_at >= LO_CYC && fall_at <= HI_CYC), 1'b1);
    chk("R8 no restart", (fall_at <= HI_CYC), 1'b1);
    chk("R6 width", low_len, PW);
    chk("R6 together", mixed, 0);
    chk("R6 released", lrst_n, 5'h1f);
    chk("R7 host kept", host_bad, 0);
    chk("R9 single pulse", falls, 1);
    bus_rd(OFS, rd);
    chk("R9 cleared", rd, 8'h00);
    bus_wr(OFS, 8'h3C);
    bus_rd(OFS, rd);
    chk("R2 after reset", rd, 8'h3C);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule